// File: doc/BRIEF.md
# JTAG Data-Register Router with Scan-Chain Selection

This block sits behind a boundary-scan TAP controller and decides which data register lies between TDI and TDO. The TAP state machine, the instruction register and the scan chains themselves are outside the block. It receives the TAP state strobes as levels that are valid for one TCK cycle, the serial input, the current 4-bit instruction, the serial output of the instruction register, and the serial outputs of up to 32 external scan chains. From these it drives a registered TDO with an enable, a test-mode control for the scan cells, and per-chain capture, shift and update strobes.

Inside the block are three data registers: a one-bit bypass stage, a fixed identification register, and a chain-number register. A chain-number instruction loads that register, and its value then chooses which external chain the internal-test instruction connects. The chosen chain stays in force through any number of other instructions, until the next chain-number update.

Top module: `tap_dr_router`

## Requirements
- R1: The instruction is 4 bits. 1100 selects internal test, 1110 selects identification, 1111 selects bypass and 0010 selects chain-number load. Every other code acts exactly as bypass: the scan cells stay in normal mode and no chain strobe fires.
- R2: The bypass register is one bit and loads 0 on capture-DR. A scan therefore returns 0 first and then TDI delayed by one cycle.
- R3: Under identification, capture-DR loads the ID_VALUE parameter into a 32-bit register. Shift-DR moves it out on TDO least significant bit first while TDI enters at the top. Update-DR leaves the register contents unchanged.
- R4: Under chain-number load, a 5-bit register sits between TDI and TDO. Capture-DR loads the current chain number into it, and shift-DR shifts it least significant bit first. Update-DR makes the shifted-in value the current chain, which appears on sel_chain.
- R5: The current chain changes only on update-DR under chain-number load. Update-DR under any other instruction leaves it unchanged.
- R6: Asynchronous reset (trst_n low) sets the current chain to 3 and drives tdo and tdo_en to 0.
- R7: Under internal test, test_mode is 1 and TDO follows chain_so of the current chain. The capture, shift and update strobes are passed only to the bit of chain_cap, chain_shift and chain_upd that has the index of the current chain. Under any other instruction, test_mode is 0 and every chain strobe is 0.
- R8: TDO and tdo_en are updated on the falling edge of TCK. tdo_en is 1 only in cycles with shift-DR or shift-IR high, and tdo is 0 whenever tdo_en is 0. In shift-IR, tdo carries ir_so.
- R9: A data register shifts only on a rising edge of TCK with shift-DR high while its instruction is active. With shift-DR low it holds, so a second scan that skips capture-DR returns the bits shifted in by the previous scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| ir | input | 4 | Current instruction |
| cap_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| ir_so | input | 1 | Serial output of the instruction register |
| chain_so | input | NUM_CHAINS | Serial outputs of the external scan chains |
| tdo | output | 1 | Registered serial test data out |
| tdo_en | output | 1 | TDO output enable |
| test_mode | output | 1 | Scan cells in test mode (1) or normal mode (0) |
| sel_chain | output | SEL_W | Current scan chain number |
| chain_cap | output | NUM_CHAINS | Capture strobe per chain |
| chain_shift | output | NUM_CHAINS | Shift strobe per chain |
| chain_upd | output | NUM_CHAINS | Update strobe per chain |

## Verification
A wrong current chain number shows on sel_chain in the cycle after an update-DR. It also shows on the next internal-test scan, because that scan returns another chain's captured pattern and disturbs a chain that should have stayed idle. A bypass or identification register that captures or shifts the wrong value shows on TDO within the first bits of the next scan. A misdecoded opcode shows the same way, or as a test_mode value that is already wrong in the same cycle. An enable or falling-edge fault on TDO shows in the first cycle after a shift state ends.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_SCAN_N = 4'b0010;
  localparam logic [IR_W-1:0] OP_INTEST = 4'b1100;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b1110;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

  typedef enum logic [1:0] {
    PATH_BYP   = 2'd0,
    PATH_ID    = 2'd1,
    PATH_SEL   = 2'd2,
    PATH_CHAIN = 2'd3
  } dr_path_e;

  // Opcode to data-register path; anything not listed falls to bypass.
  function automatic dr_path_e decode_path(input logic [IR_W-1:0] op);
    case (op)
      OP_INTEST: return PATH_CHAIN;
      OP_IDCODE: return PATH_ID;
      OP_SCAN_N: return PATH_SEL;
      default:   return PATH_BYP;
    endcase
  endfunction

  // True when a chain index matches the current selection.
  function automatic logic chain_hit(input int unsigned idx, input int unsigned sel);
    return idx == sel;
  endfunction

endpackage

// File: rtl/tap_dr_shift.sv
module tap_dr_shift #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         en,
  input  logic         capture,
  input  logic         shift,
  input  logic [W-1:0] cap_val,
  input  logic         si,
  output logic [W-1:0] q,
  output logic         so
);

  generate
    if (W == 1) begin : g_one
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             q <= RST_VAL;
        else if (en && capture)  q <= cap_val;
        else if (en && shift)    q <= si;
      end
    end else begin : g_many
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             q <= RST_VAL;
        else if (en && capture)  q <= cap_val;
        else if (en && shift)    q <= {si, q[W-1:1]};
      end
    end
  endgenerate

  assign so = q[0];

endmodule

// File: rtl/tap_chain_sel.sv
module tap_chain_sel #(
  parameter int SEL_W     = 5,
  parameter int RST_CHAIN = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] nxt,
  output logic [SEL_W-1:0] sel
);

  localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(RST_CHAIN);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   sel <= RST_SEL;
    else if (load) sel <= nxt;
  end

endmodule

// File: rtl/tap_chain_fanout.sv
module tap_chain_fanout
  import tap_sel_pkg::*;
#(
  parameter int NUM_CHAINS = 32,
  parameter int SEL_W      = 5
) (
  input  logic                  en,
  input  logic                  cap,
  input  logic                  shift,
  input  logic                  upd,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NUM_CHAINS-1:0] chain_so,
  output logic [NUM_CHAINS-1:0] chain_cap,
  output logic [NUM_CHAINS-1:0] chain_shift,
  output logic [NUM_CHAINS-1:0] chain_upd,
  output logic                  so
);

  logic [NUM_CHAINS-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chain
      assign hit[i]         = en & chain_hit(i, int'(sel));
      assign chain_cap[i]   = hit[i] & cap;
      assign chain_shift[i] = hit[i] & shift;
      assign chain_upd[i]   = hit[i] & upd;
    end
  endgenerate

  // A selection beyond the last chain matches nothing and returns 0.
  assign so = |(hit & chain_so);

endmodule

// File: rtl/tap_tdo_stage.sv
module tap_tdo_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic shift_dr,
  input  logic shift_ir,
  input  logic dr_so,
  input  logic ir_so,
  output logic tdo,
  output logic tdo_en
);

  logic tdo_q;
  logic en_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= shift_ir ? ir_so : dr_so;
      en_q  <= shift_dr | shift_ir;
    end
  end

  assign tdo    = en_q & tdo_q;
  assign tdo_en = en_q;

endmodule

// File: rtl/tap_dr_router.sv
module tap_dr_router
  import tap_sel_pkg::*;
#(
  parameter int                NUM_CHAINS = 32,
  parameter int                SEL_W      = 5,
  parameter int                ID_W       = 32,
  parameter logic [ID_W-1:0]   ID_VALUE   = 32'h4A7B_2C93,
  parameter int                RST_CHAIN  = 3
) (
  input  logic                  tck,
  input  logic                  trst_n,
  input  logic                  tdi,
  input  logic [3:0]            ir,
  input  logic                  cap_dr,
  input  logic                  shift_dr,
  input  logic                  upd_dr,
  input  logic                  shift_ir,
  input  logic                  ir_so,
  input  logic [NUM_CHAINS-1:0] chain_so,
  output logic                  tdo,
  output logic                  tdo_en,
  output logic                  test_mode,
  output logic [SEL_W-1:0]      sel_chain,
  output logic [NUM_CHAINS-1:0] chain_cap,
  output logic [NUM_CHAINS-1:0] chain_shift,
  output logic [NUM_CHAINS-1:0] chain_upd
);

  localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(RST_CHAIN);

  // Named internal events for the checker.
  dr_path_e         path;
  logic             on_byp, on_id, on_sel, on_chain;
  logic             byp_q, byp_so;
  logic [ID_W-1:0]  id_q;
  logic             id_so;
  logic [SEL_W-1:0] sel_shadow;
  logic             sel_so;
  logic             sel_load;
  logic             chain_sel_so;
  logic             dr_so;

  assign path     = decode_path(ir);
  assign on_byp   = (path == PATH_BYP);
  assign on_id    = (path == PATH_ID);
  assign on_sel   = (path == PATH_SEL);
  assign on_chain = (path == PATH_CHAIN);
  assign sel_load = on_sel & upd_dr;

  tap_dr_shift #(.W(1), .RST_VAL(1'b0)) u_byp (
    .tck(tck), .trst_n(trst_n), .en(on_byp), .capture(cap_dr), .shift(shift_dr),
    .cap_val(1'b0), .si(tdi), .q(byp_q), .so(byp_so)
  );

  tap_dr_shift #(.W(ID_W), .RST_VAL(ID_VALUE)) u_id (
    .tck(tck), .trst_n(trst_n), .en(on_id), .capture(cap_dr), .shift(shift_dr),
    .cap_val(ID_VALUE), .si(tdi), .q(id_q), .so(id_so)
  );

  tap_dr_shift #(.W(SEL_W), .RST_VAL(RST_SEL)) u_selsr (
    .tck(tck), .trst_n(trst_n), .en(on_sel), .capture(cap_dr), .shift(shift_dr),
    .cap_val(sel_chain), .si(tdi), .q(sel_shadow), .so(sel_so)
  );

  tap_chain_sel #(.SEL_W(SEL_W), .RST_CHAIN(RST_CHAIN)) u_cur (
    .tck(tck), .trst_n(trst_n), .load(sel_load), .nxt(sel_shadow), .sel(sel_chain)
  );

  tap_chain_fanout #(.NUM_CHAINS(NUM_CHAINS), .SEL_W(SEL_W)) u_fan (
    .en(on_chain), .cap(cap_dr), .shift(shift_dr), .upd(upd_dr),
    .sel(sel_chain), .chain_so(chain_so),
    .chain_cap(chain_cap), .chain_shift(chain_shift), .chain_upd(chain_upd),
    .so(chain_sel_so)
  );

  always_comb begin
    case (path)
      PATH_ID:    dr_so = id_so;
      PATH_SEL:   dr_so = sel_so;
      PATH_CHAIN: dr_so = chain_sel_so;
      default:    dr_so = byp_so;
    endcase
  end

  assign test_mode = on_chain;

  tap_tdo_stage u_out (
    .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .shift_ir(shift_ir),
    .dr_so(dr_so), .ir_so(ir_so), .tdo(tdo), .tdo_en(tdo_en)
  );

endmodule

// File: rtl/tap_dr_router_chk.sv
module tap_dr_router_chk
  import tap_sel_pkg::*;
#(
  parameter int NUM_CHAINS = 32,
  parameter int SEL_W      = 5,
  parameter int ID_W       = 32
) (
  input logic                  tck,
  input logic                  trst_n,
  input logic [3:0]            ir,
  input logic                  cap_dr,
  input logic                  shift_dr,
  input logic                  upd_dr,
  input logic                  shift_ir,
  input logic                  tdo_en,
  input logic                  test_mode,
  input logic [SEL_W-1:0]      sel_chain,
  input logic [NUM_CHAINS-1:0] chain_cap,
  input logic [NUM_CHAINS-1:0] chain_shift,
  input logic [NUM_CHAINS-1:0] chain_upd,
  input logic [SEL_W-1:0]      sel_shadow,
  input logic                  byp_q,
  input logic [ID_W-1:0]       id_q
);

  p_mode_r1: assert property (@(posedge tck) disable iff (!trst_n)
    test_mode == (ir == OP_INTEST));

  p_byp_zero_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_BYPASS && cap_dr) |=> (byp_q == 1'b0));

  p_id_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_IDCODE && upd_dr && !cap_dr && !shift_dr) |=> $stable(id_q));

  p_sel_load_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_SCAN_N && upd_dr) |=> (sel_chain == $past(sel_shadow)));

  p_sel_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != OP_SCAN_N) |=> $stable(sel_chain));

  p_onehot_r7: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(chain_cap) && $onehot0(chain_shift) && $onehot0(chain_upd));

  p_strobe_mode_r7: assert property (@(posedge tck) disable iff (!trst_n)
    ((chain_cap | chain_shift | chain_upd) != '0) |-> test_mode);

  p_tdo_en_r8: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (shift_dr || shift_ir));

endmodule

bind tap_dr_router tap_dr_router_chk #(
  .NUM_CHAINS(NUM_CHAINS), .SEL_W(SEL_W), .ID_W(ID_W)
) u_chk (
  .tck(tck), .trst_n(trst_n), .ir(ir), .cap_dr(cap_dr), .shift_dr(shift_dr),
  .upd_dr(upd_dr), .shift_ir(shift_ir), .tdo_en(tdo_en), .test_mode(test_mode),
  .sel_chain(sel_chain), .chain_cap(chain_cap), .chain_shift(chain_shift),
  .chain_upd(chain_upd), .sel_shadow(sel_shadow), .byp_q(byp_q), .id_q(id_q)
);

// File: tb/tap_dr_router_test.sv
module tap_dr_router_test;

  localparam int          NC   = 32;
  localparam int          SW   = 5;
  localparam int          CW   = 8;
  localparam logic [31:0] IDV  = 32'h4A7B_2C93;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tdi = 1'b0;
  logic [3:0]    ir = 4'b1111;
  logic          cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, shift_ir = 1'b0;
  logic          ir_so = 1'b0;
  logic [NC-1:0] chain_so;
  logic          tdo, tdo_en, test_mode;
  logic [SW-1:0] sel_chain;
  logic [NC-1:0] chain_cap, chain_shift, chain_upd;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 tck = ~tck;

  tap_dr_router #(.NUM_CHAINS(NC), .SEL_W(SW), .ID_W(32), .ID_VALUE(IDV), .RST_CHAIN(3)) uut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .ir(ir), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .upd_dr(upd_dr), .shift_ir(shift_ir), .ir_so(ir_so), .chain_so(chain_so),
    .tdo(tdo), .tdo_en(tdo_en), .test_mode(test_mode), .sel_chain(sel_chain),
    .chain_cap(chain_cap), .chain_shift(chain_shift), .chain_upd(chain_upd)
  );

  // External scan chains modelled in the bench.
  logic [CW-1:0] creg [NC];

  function automatic logic [CW-1:0] cap_pat(input int i);
    return CW'(i * 37 + 5) ^ 8'hA0;
  endfunction

  always @(posedge tck or negedge trst_n) begin
    for (int i = 0; i < NC; i++) begin
      if (!trst_n)             creg[i] <= '0;
      else if (chain_cap[i])   creg[i] <= cap_pat(i);
      else if (chain_shift[i]) creg[i] <= {tdi, creg[i][CW-1:1]};
    end
  end

  always_comb begin
    for (int i = 0; i < NC; i++) chain_so[i] = creg[i][0];
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One TCK cycle: drive after the rising edge, sample after the falling edge.
  task automatic cyc(input logic c, input logic s, input logic u, input logic si_ir,
                     input logic d, output logic tdo_s, output logic en_s);
    @(posedge tck);
    #1;
    cap_dr = c; shift_dr = s; upd_dr = u; shift_ir = si_ir; tdi = d;
    #3;
    tdo_s = tdo;
    en_s  = tdo_en;
  endtask

  task automatic idle();
    logic a, b;
    cyc(0, 0, 0, 0, 0, a, b);
  endtask

  task automatic scan(input int n, input logic [63:0] din, input bit do_cap,
                      input bit do_upd, output logic [63:0] dout);
    logic t, e;
    dout = '0;
    if (do_cap) cyc(1, 0, 0, 0, 0, t, e);
    for (int k = 0; k < n; k++) begin
      cyc(0, 1, 0, 0, din[k], t, e);
      dout[k] = t;
    end
    if (do_upd) cyc(0, 0, 1, 0, 0, t, e);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [SW-1:0] prev;
    logic t, e;

    #12;
    trst_n = 1'b1;
    idle();
    // R6 reset state
    chk(tdo == 1'b0, "R6 tdo after reset", 64'(tdo), 0);
    chk(tdo_en == 1'b0, "R6 tdo_en after reset", 64'(tdo_en), 0);
    chk(sel_chain == 5'd3, "R6 chain after reset", 64'(sel_chain), 3);
    chk(test_mode == 1'b0, "R1 bypass normal mode", 64'(test_mode), 0);

    // R4 R7 R9 sweep every chain
    prev = 5'd3;
    for (int n = 0; n < NC; n++) begin
      logic [CW-1:0] p;
      logic [CW-1:0] other_before;
      int o;
      ir = 4'b0010;
      scan(SW, 64'(n), 1, 1, d);
      chk(d[SW-1:0] == prev, "R4 capture of current chain", d, 64'(prev));
      chk(sel_chain == SW'(n), "R4 update sets chain", 64'(sel_chain), 64'(n));
      prev = SW'(n);
      o = (n + 1) % NC;
      other_before = creg[o];
      ir = 4'b1100;
      #0;
      chk(test_mode == 1'b1, "R7 test mode under internal test", 64'(test_mode), 1);
      p = CW'(n * 11 + 3);
      scan(CW, 64'(p), 1, 1, d);
      chk(d[CW-1:0] == cap_pat(n), "R7 selected chain on tdo", d, 64'(cap_pat(n)));
      scan(CW, 64'(~p), 0, 0, d);
      chk(d[CW-1:0] == p, "R9 shifted data returns", d, 64'(p));
      chk(creg[o] == other_before, "R7 unselected chain untouched", 64'(creg[o]), 64'(other_before));
      chk(sel_chain == SW'(n), "R5 chain kept under internal test", 64'(sel_chain), 64'(n));
    end

    // select chain 17 and keep it through other instructions
    ir = 4'b0010;
    scan(SW, 64'd17, 1, 1, d);

    // R3 identification
    ir = 4'b1110;
    #0;
    chk(test_mode == 1'b0, "R7 normal mode under identification", 64'(test_mode), 0);
    scan(32, 64'hDEAD_BEEF, 1, 1, d);
    chk(d[31:0] == IDV, "R3 id value on tdo", d, 64'(IDV));
    scan(32, 64'h1234_5678, 0, 0, d);
    chk(d[31:0] == 32'hDEAD_BEEF, "R3 update leaves id register", d, 64'hDEAD_BEEF);
    scan(32, 64'h0, 1, 0, d);
    chk(d[31:0] == IDV, "R3 recapture of id", d, 64'(IDV));
    chk(sel_chain == 5'd17, "R5 chain kept under identification", 64'(sel_chain), 17);

    // R2 bypass
    ir = 4'b1111;
    scan(8, 64'hB6, 1, 1, d);
    chk(d[7:0] == 8'h6C, "R2 bypass delay", d, 64'h6C);
    scan(8, 64'h5A, 1, 1, d);
    chk(d[7:0] == 8'hB4, "R2 bypass capture zero", d, 64'hB4);
    chk(sel_chain == 5'd17, "R5 chain kept under bypass", 64'(sel_chain), 17);

    // R1 undefined opcodes act as bypass
    for (int op = 0; op < 16; op++) begin
      logic [5:0] din;
      if (op == 2 || op == 12 || op == 14 || op == 15) continue;
      ir = 4'(op);
      din = 6'(op * 5 + 33);
      scan(6, 64'(din), 1, 1, d);
      chk(d[5:0] == {din[4:0], 1'b0}, "R1 undefined opcode as bypass", d, 64'({din[4:0], 1'b0}));
      chk(test_mode == 1'b0, "R1 undefined opcode normal mode", 64'(test_mode), 0);
      chk(sel_chain == 5'd17, "R5 chain kept under undefined opcode", 64'(sel_chain), 17);
    end

    // R8 tdo timing and enable
    ir_so = 1'b1;
    cyc(0, 0, 0, 1, 0, t, e);
    chk(t == 1'b1 && e == 1'b1, "R8 shift-IR carries ir_so", 64'({e, t}), 3);
    ir_so = 1'b0;
    cyc(0, 0, 0, 1, 0, t, e);
    chk(t == 1'b0 && e == 1'b1, "R8 shift-IR low bit", 64'({e, t}), 2);
    ir_so = 1'b1;
    cyc(0, 0, 0, 0, 1, t, e);
    chk(t == 1'b0 && e == 1'b0, "R8 quiet outside shift", 64'({e, t}), 0);
    ir = 4'b1110;
    cyc(1, 0, 0, 0, 0, t, e);
    chk(e == 1'b0, "R8 no enable in capture", 64'(e), 0);
    cyc(0, 1, 0, 0, 0, t, e);
    chk(t == IDV[0] && e == 1'b1, "R8 first shift bit", 64'({e, t}), 64'({1'b1, IDV[0]}));
    ir_so = 1'b0;
    idle();

    // R6 reset mid-run
    trst_n = 1'b0;
    #1;
    chk(sel_chain == 5'd3, "R6 chain back to 3", 64'(sel_chain), 3);
    chk(tdo == 1'b0 && tdo_en == 1'b0, "R6 tdo cleared", 64'({tdo_en, tdo}), 0);
    #5;
    trst_n = 1'b1;
    ir = 4'b0010;
    scan(SW, 64'd9, 1, 0, d);
    chk(d[SW-1:0] == 5'd3, "R4 capture after reset", d, 3);
    chk(sel_chain == 5'd3, "R4 no update without update-DR", 64'(sel_chain), 3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule